// File: doc/BRIEF.md
# Bidirectional Inter-Processor Mailbox

This block lets two processors, called side A and side B, pass 32-bit words to each other through two independent one-way queues. Mailbox 0 carries words from B to A. Mailbox 1 carries words from A to B. Each processor has its own simple register port, made of a select, a write flag, a 6-bit byte address and 32-bit write and read data. Through that port it can push into its outbound mailbox, pop from its inbound mailbox, and observe the status and configuration of both mailboxes.

Words are opaque to the hardware. No bit of a word is decoded, including the low nibble that software may use as a channel tag. Each mailbox raises a level interrupt toward its reader while it holds data and its enable bit is set. A typical use passes a buffer pointer with a channel tag in one direction and waits for a reply in the other, either by polling the empty flag or by taking the interrupt.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both mailboxes are empty: status reads 0x40000000, configuration reads 0, and irqA and irqB are low.
- R2: A word that side A writes to address 0x20 is returned, unchanged in all 32 bits, by side B reads of address 0x20, in first-in first-out order. Read data appears on the side's rdata output the cycle after the read request.
- R3: A word that side B writes to address 0x00 is returned, unchanged in all 32 bits, by side A reads of address 0x00, in first-in first-out order.
- R4: The status register is at offset 0x18 of a mailbox block: address 0x18 for mailbox 0 and 0x38 for mailbox 1. Its fields are:
  - bit 31: full, set when 8 words are held;
  - bit 30: empty;
  - bits [7:4]: the number of words held;
  - bit 0: the overflow flag;
  - all other bits read 0.
- R5: A push into a full mailbox is dropped and leaves the stored words unchanged. It sets the overflow bit (status bit 0), which then stays set. Writing 1 to status bit 0 clears it. Writing 0 to status bit 0 leaves it unchanged.
- R6: A read of the inbound data register while that mailbox is empty returns 0 and changes neither pointer. A later push and pop then behave normally.
- R7: The configuration register is at offset 0x1C: address 0x1C for mailbox 0 and 0x3C for mailbox 1. Its bit 0 is the interrupt enable. irqA equals (mailbox 0 enable AND mailbox 0 not empty). irqB equals (mailbox 1 enable AND mailbox 1 not empty). Either output follows the clock edge that changes the enable or the fill level.
- R8: A side cannot use the other direction:
  - a write to its own inbound data address is ignored;
  - a read of its own outbound data address returns 0 and pops nothing.
- R9: Both sides can read the status and configuration registers of both mailboxes.
- R10: If the same mailbox gets a push and a pop in one cycle, both take effect. The fill count is unchanged and order is kept.
- R11: If both sides write the same configuration register in one cycle, side A's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aSel | input | 1 | Side A access request |
| aWr | input | 1 | Side A write (1) or read (0) |
| aAddr | input | 6 | Side A byte address |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data, registered |
| bSel | input | 1 | Side B access request |
| bWr | input | 1 | Side B write (1) or read (0) |
| bAddr | input | 6 | Side B byte address |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data, registered |
| irqA | output | 1 | Data-available interrupt toward side A (mailbox 0) |
| irqB | output | 1 | Data-available interrupt toward side B (mailbox 1) |

## Verification
Every bus access is driven on a falling edge and commits on the next rising edge. Read data, the new status fields and the interrupt levels are therefore all due one cycle after the request. The bench samples each of them at the falling edge that follows the committing edge, and never earlier. A scoreboard queue per direction predicts each popped word, and a fill counter per mailbox predicts the status word. The simultaneous push-and-pop case is driven on both ports in the same cycle, and its effect on the count is read back one cycle later.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int MBOX_DATA_W = 32;
  localparam int MBOX_ADDR_W = 6;
  localparam int MBOX_COUNT = 2;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CFG  = 2'd2,
    REG_NONE = 2'd3
  } regKind_e;

  typedef struct packed {
    logic                   push;
    logic                   pop;
    logic [MBOX_DATA_W-1:0] pushData;
    logic                   cfgWe;
    logic                   cfgEn;
    logic                   ovfClr;
  } mboxStrobe_t;

  function automatic regKind_e decodeReg(input logic [4:0] off);
    case (off)
      5'h00:   return REG_DATA;
      5'h18:   return REG_STAT;
      5'h1C:   return REG_CFG;
      default: return REG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  mboxStrobe_t [MBOX_COUNT-1:0]             stb,
  output logic [MBOX_COUNT-1:0][MBOX_DATA_W-1:0]   head,
  output logic [MBOX_COUNT-1:0][CNT_W-1:0]         cnt,
  output logic [MBOX_COUNT-1:0]                    full,
  output logic [MBOX_COUNT-1:0]                    empty,
  output logic [MBOX_COUNT-1:0]                    ovf,
  output logic [MBOX_COUNT-1:0]                    en,
  output logic [MBOX_COUNT-1:0]                    irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  for (genvar m = 0; m < MBOX_COUNT; m++) begin : g_box
    logic [MBOX_DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] cntQ;
    logic ovfQ, enQ;
    logic accept, take;

    assign accept = stb[m].push && (cntQ != CNT_MAX);
    assign take   = stb[m].pop && (cntQ != '0);

    always_ff @(posedge clk) begin
      if (accept) mem[wrPtr] <= stb[m].pushData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cntQ  <= '0;
        ovfQ  <= 1'b0;
        enQ   <= 1'b0;
      end else begin
        if (accept) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
        if (take)   rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
        case ({accept, take})
          2'b10:   cntQ <= cntQ + 1'b1;
          2'b01:   cntQ <= cntQ - 1'b1;
          default: cntQ <= cntQ;
        endcase
        if (stb[m].push && !accept) ovfQ <= 1'b1;
        else if (stb[m].ovfClr)     ovfQ <= 1'b0;
        if (stb[m].cfgWe) enQ <= stb[m].cfgEn;
      end
    end

    assign head[m]  = mem[rdPtr];
    assign cnt[m]   = cntQ;
    assign full[m]  = (cntQ == CNT_MAX);
    assign empty[m] = (cntQ == '0);
    assign ovf[m]   = ovfQ;
    assign en[m]    = enQ;
    assign irq[m]   = enQ && (cntQ != '0);
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   aSel,
  input  logic                                   aWr,
  input  logic [MBOX_ADDR_W-1:0]                 aAddr,
  input  logic [MBOX_DATA_W-1:0]                 aWdata,
  output logic [MBOX_DATA_W-1:0]                 aRdata,
  input  logic                                   bSel,
  input  logic                                   bWr,
  input  logic [MBOX_ADDR_W-1:0]                 bAddr,
  input  logic [MBOX_DATA_W-1:0]                 bWdata,
  output logic [MBOX_DATA_W-1:0]                 bRdata,
  input  logic [MBOX_COUNT-1:0][MBOX_DATA_W-1:0] head,
  input  logic [MBOX_COUNT-1:0][CNT_W-1:0]       cnt,
  input  logic [MBOX_COUNT-1:0]                  full,
  input  logic [MBOX_COUNT-1:0]                  empty,
  input  logic [MBOX_COUNT-1:0]                  ovf,
  input  logic [MBOX_COUNT-1:0]                  en,
  output mboxStrobe_t [MBOX_COUNT-1:0]           stb
);
  regKind_e aKind, bKind;
  logic aBox, bBox;
  logic [MBOX_COUNT-1:0][MBOX_DATA_W-1:0] statWord;
  logic [MBOX_DATA_W-1:0] aRdNext, bRdNext;

  assign aKind = decodeReg(aAddr[4:0]);
  assign bKind = decodeReg(bAddr[4:0]);
  assign aBox  = aAddr[5];
  assign bBox  = bAddr[5];

  // Mailbox 0: B pushes, A pops. Mailbox 1: A pushes, B pops.
  for (genvar m = 0; m < MBOX_COUNT; m++) begin : g_stb
    logic aHit, bHit, aCfg, bCfg, aStat, bStat;
    assign aHit  = aSel && aWr && (aBox == 1'(m));
    assign bHit  = bSel && bWr && (bBox == 1'(m));
    assign aCfg  = aHit && (aKind == REG_CFG);
    assign bCfg  = bHit && (bKind == REG_CFG);
    assign aStat = aHit && (aKind == REG_STAT) && aWdata[0];
    assign bStat = bHit && (bKind == REG_STAT) && bWdata[0];

    if (m == 0) begin : g_in_a
      assign stb[m].push     = bHit && (bKind == REG_DATA);
      assign stb[m].pushData = bWdata;
      assign stb[m].pop      = aSel && !aWr && !aBox && (aKind == REG_DATA) && !empty[m];
    end else begin : g_in_b
      assign stb[m].push     = aHit && (aKind == REG_DATA);
      assign stb[m].pushData = aWdata;
      assign stb[m].pop      = bSel && !bWr && bBox && (bKind == REG_DATA) && !empty[m];
    end

    assign stb[m].cfgWe  = aCfg || bCfg;
    assign stb[m].cfgEn  = aCfg ? aWdata[0] : bWdata[0];
    assign stb[m].ovfClr = aStat || bStat;

    assign statWord[m] = {full[m], empty[m], 22'b0, 4'(cnt[m]), 3'b0, ovf[m]};
  end

  always_comb begin
    aRdNext = '0;
    case (aKind)
      REG_DATA: if (!aBox && !empty[0]) aRdNext = head[0];
      REG_STAT: aRdNext = statWord[aBox];
      REG_CFG:  aRdNext = {31'b0, en[aBox]};
      default:  aRdNext = '0;
    endcase
  end

  always_comb begin
    bRdNext = '0;
    case (bKind)
      REG_DATA: if (bBox && !empty[1]) bRdNext = head[1];
      REG_STAT: bRdNext = statWord[bBox];
      REG_CFG:  bRdNext = {31'b0, en[bBox]};
      default:  bRdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aRdata <= '0;
      bRdata <= '0;
    end else begin
      if (aSel && !aWr) aRdata <= aRdNext;
      if (bSel && !bWr) bRdata <= bRdNext;
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        aSel,
  input  logic        aWr,
  input  logic [5:0]  aAddr,
  input  logic [31:0] aWdata,
  output logic [31:0] aRdata,
  input  logic        bSel,
  input  logic        bWr,
  input  logic [5:0]  bAddr,
  input  logic [31:0] bWdata,
  output logic [31:0] bRdata,
  output logic        irqA,
  output logic        irqB
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  mboxStrobe_t [MBOX_COUNT-1:0]           stb;
  logic [MBOX_COUNT-1:0][MBOX_DATA_W-1:0] head;
  logic [MBOX_COUNT-1:0][CNT_W-1:0]       cntVec;
  logic [MBOX_COUNT-1:0] fullVec, emptyVec, ovfVec, enVec, irqVec;

  mbox_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aSel(aSel), .aWr(aWr), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bSel(bSel), .bWr(bWr), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata),
    .head(head), .cnt(cntVec), .full(fullVec), .empty(emptyVec),
    .ovf(ovfVec), .en(enVec), .stb(stb)
  );

  mbox_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .head(head), .cnt(cntVec), .full(fullVec), .empty(emptyVec),
    .ovf(ovfVec), .en(enVec), .irq(irqVec)
  );

  assign irqA = irqVec[0];
  assign irqB = irqVec[1];
endmodule

// File: rtl/ipc_mailbox_checker.sv
module ipc_mailbox_checker
  import ipc_mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                             clk,
  input logic                             rstN,
  input mboxStrobe_t [MBOX_COUNT-1:0]     stb,
  input logic [MBOX_COUNT-1:0][CNT_W-1:0] cnt,
  input logic [MBOX_COUNT-1:0]            ovf,
  input logic [MBOX_COUNT-1:0]            en,
  input logic                             aSel,
  input logic                             aWr,
  input logic [5:0]                       aAddr,
  input logic                             bSel,
  input logic                             bWr,
  input logic [31:0]                      aRdata,
  input logic                             irqA,
  input logic                             irqB
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt[0] <= CNT_MAX && cnt[1] <= CNT_MAX);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb[1].push && !stb[1].pop && cnt[1] == CNT_MAX |=> cnt[1] == CNT_MAX && ovf[1]);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    aSel && !aWr && aAddr == 6'h00 && cnt[0] == '0 && !stb[0].push |=> aRdata == '0 && cnt[0] == '0);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!en[0] |-> !irqA) and (cnt[1] == '0 |-> !irqB));

  assert_wrong_way_push_R8: assert property (@(posedge clk) disable iff (!rstN)
    aSel && aWr && aAddr == 6'h00 && !bSel |=> $stable(cnt[0]));

  assert_push_pop_same_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb[1].push && stb[1].pop && cnt[1] != CNT_MAX |=> $stable(cnt[1]));
endmodule

bind ipc_mailbox ipc_mailbox_checker #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .stb(stb), .cnt(cntVec), .ovf(ovfVec), .en(enVec),
  .aSel(aSel), .aWr(aWr), .aAddr(aAddr), .bSel(bSel), .bWr(bWr),
  .aRdata(aRdata), .irqA(irqA), .irqB(irqB)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aSel = 0, aWr = 0, bSel = 0, bWr = 0;
  logic [5:0] aAddr = '0, bAddr = '0;
  logic [31:0] aWdata = '0, bWdata = '0;
  logic [31:0] aRdata, bRdata;
  logic irqA, irqB;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // scoreboard state: queue per direction, model fill and overflow
  logic [31:0] qBA[$];  // mailbox 0
  logic [31:0] qAB[$];  // mailbox 1
  int mCnt[2] = '{0, 0};
  bit mOvf[2] = '{0, 0};

  always #4 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rstN(rstN),
    .aSel(aSel), .aWr(aWr), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bSel(bSel), .bWr(bWr), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata),
    .irqA(irqA), .irqB(irqB)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStat(input int m);
    return {mCnt[m] == 8, mCnt[m] == 0, 22'b0, 4'(mCnt[m]), 3'b0, mOvf[m]};
  endfunction

  task automatic busWrite(input bit sideB, input logic [5:0] addr, input logic [31:0] d);
    @(negedge clk);
    if (sideB) begin bSel = 1; bWr = 1; bAddr = addr; bWdata = d; end
    else       begin aSel = 1; aWr = 1; aAddr = addr; aWdata = d; end
    @(negedge clk);
    aSel = 0; bSel = 0; aWr = 0; bWr = 0;
  endtask

  task automatic busRead(input bit sideB, input logic [5:0] addr, output logic [31:0] d);
    @(negedge clk);
    if (sideB) begin bSel = 1; bWr = 0; bAddr = addr; end
    else       begin aSel = 1; aWr = 0; aAddr = addr; end
    @(negedge clk);
    d = sideB ? bRdata : aRdata;
    aSel = 0; bSel = 0;
  endtask

  // driver: push through the correct side, predict acceptance
  task automatic pushTo(input int m, input logic [31:0] d);
    busWrite(m == 0, m == 0 ? 6'h00 : 6'h20, d);
    if (mCnt[m] < 8) begin
      if (m == 0) qBA.push_back(d); else qAB.push_back(d);
      mCnt[m]++;
    end else mOvf[m] = 1;
  endtask

  // monitor: pop from the reading side, compare with scoreboard
  task automatic popFrom(input int m, input string req);
    logic [31:0] got, exp;
    busRead(m == 1, m == 0 ? 6'h00 : 6'h20, got);
    if (mCnt[m] > 0) begin
      exp = (m == 0) ? qBA.pop_front() : qAB.pop_front();
      mCnt[m]--;
    end else exp = 0;
    check(got === exp, req, got, exp);
  endtask

  task automatic checkStat(input bit sideB, input int m, input string req);
    logic [31:0] got;
    busRead(sideB, m == 0 ? 6'h18 : 6'h38, got);
    check(got === expStat(m), req, got, expStat(m));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    check(irqA === 0 && irqB === 0, "R1 irq", {30'b0, irqA, irqB}, 0);
    checkStat(0, 0, "R1 status mbox0");
    checkStat(1, 1, "R1 status mbox1");
    busRead(0, 6'h1C, got); check(got === 0, "R1 cfg0", got, 0);
    busRead(1, 6'h3C, got); check(got === 0, "R1 cfg1", got, 0);

    // R2 A->B path, all bits preserved including low nibble
    pushTo(1, 32'hDEAD_BEE8);
    pushTo(1, 32'h0000_000F);
    pushTo(1, 32'hFFFF_FFF1);
    checkStat(1, 1, "R4 count 3");
    checkStat(0, 1, "R9 A reads mbox1 status");
    for (int i = 0; i < 3; i++) popFrom(1, "R2 order");
    checkStat(1, 1, "R4 empty after drain");

    // R3 B->A path
    pushTo(0, 32'h1234_5678);
    pushTo(0, 32'hA5A5_5A5A);
    checkStat(1, 0, "R9 B reads mbox0 status");
    popFrom(0, "R3 order");
    popFrom(0, "R3 order");

    // R4 full and R5 drop/overflow
    for (int i = 0; i < 8; i++) pushTo(1, 32'h100 + i);
    checkStat(1, 1, "R4 full");
    pushTo(1, 32'hBAD0_0000);
    checkStat(1, 1, "R5 overflow set");
    busWrite(0, 6'h38, 32'h0);
    checkStat(1, 1, "R5 write 0 keeps overflow");
    busWrite(0, 6'h38, 32'h1); mOvf[1] = 0;
    checkStat(1, 1, "R5 overflow cleared");
    for (int i = 0; i < 8; i++) popFrom(1, "R5 contents kept");

    // R6 empty read
    popFrom(1, "R6 empty read zero");
    checkStat(1, 1, "R6 still empty");
    pushTo(1, 32'hCAFE_0003);
    popFrom(1, "R6 normal after empty read");

    // R7 interrupts
    busWrite(1, 6'h3C, 32'h1);
    check(irqB === 0, "R7 irqB enabled but empty", irqB, 0);
    pushTo(1, 32'h7);
    check(irqB === 1, "R7 irqB on data", irqB, 1);
    busWrite(1, 6'h3C, 32'h0);
    check(irqB === 0, "R7 irqB disabled", irqB, 0);
    busWrite(1, 6'h3C, 32'h1);
    check(irqB === 1, "R7 irqB reenabled", irqB, 1);
    popFrom(1, "R7 pop");
    check(irqB === 0, "R7 irqB after drain", irqB, 0);
    busWrite(0, 6'h1C, 32'h1);
    pushTo(0, 32'h55);
    check(irqA === 1 && irqB === 0, "R7 irqA on data", {30'b0, irqA, irqB}, 2);
    popFrom(0, "R7 pop A");
    check(irqA === 0, "R7 irqA after drain", irqA, 0);
    busRead(1, 6'h1C, got); check(got === 1, "R9 B reads cfg0", got, 1);

    // R8 wrong-direction access
    busWrite(0, 6'h00, 32'hEEEE_0000);
    checkStat(0, 0, "R8 A write to inbound ignored");
    pushTo(1, 32'h0BAD_F00D);
    busRead(0, 6'h20, got); check(got === 0, "R8 A read outbound zero", got, 0);
    checkStat(1, 1, "R8 no pop by A");
    popFrom(1, "R8 word intact");

    // R10 simultaneous push and pop on mailbox 1
    pushTo(1, 32'h1111_1111);
    @(negedge clk);
    aSel = 1; aWr = 1; aAddr = 6'h20; aWdata = 32'h2222_2222;
    bSel = 1; bWr = 0; bAddr = 6'h20;
    @(negedge clk);
    got = bRdata;
    aSel = 0; bSel = 0; aWr = 0;
    check(got === 32'h1111_1111, "R10 pop value", got, 32'h1111_1111);
    void'(qAB.pop_front()); qAB.push_back(32'h2222_2222);
    checkStat(1, 1, "R10 count unchanged");
    popFrom(1, "R10 pushed word");

    // R11 simultaneous config writes, side A wins
    @(negedge clk);
    aSel = 1; aWr = 1; aAddr = 6'h3C; aWdata = 32'h1;
    bSel = 1; bWr = 1; bAddr = 6'h3C; bWdata = 32'h0;
    @(negedge clk);
    aSel = 0; bSel = 0; aWr = 0; bWr = 0;
    busRead(1, 6'h3C, got); check(got === 1, "R11 side A wins", got, 1);

    finished = 1;
    summary();
  end
endmodule